// File: doc/BRIEF.md
# Clock Frequency Window Checker

This block measures the rate of one of several on-chip clocks against a steady reference clock and decides whether that rate falls inside a programmed acceptance window. A multiplexer picks the clock under test. While the reference clock runs through a fixed gate of 512 cycles, a counter in the measured clock's own domain counts its rising edges. The result then crosses back to the bus clock, where it is held, flagged as done and compared against a low and a high bound.

Software drives it through two words. A control/status word carries the enable, the start, the source select, the done and pass flags and the returned count. A limit word carries the two bounds. The usual flow is to write zero and wait for the count to read zero, then write enable together with a source, wait a short settling time, add start, and poll for done. The measured frequency is reference / 512 × (count + 1). Software derives the bounds from that relation, typically with a margin of a couple of percent.

Top module: `freqwin_checker`

## Requirements
- R1: After reset both the status word and the limit word read as all zeros.
- R2: In the status word, bit 0 (enable), bit 1 (start) and bits [5:2] (source select) read back as last written. Bit 6 (done), bit 7 (pass) and bits [29:16] (count) are read-only. Bits [15:8] and [31:30] read zero.
- R3: A write to the limit word stores the low bound in bits [29:16] and the high bound in bits [13:0]. It reads back exactly those fields, and every other bit reads zero.
- R4: With enable and start set, done rises once a 512-cycle reference gate has elapsed. The count equals the number of measured-clock rising edges inside the gate minus one, within ±1 edge.
- R5: A source fast enough to overflow the 14-bit count reports 0x3FFF instead of wrapping.
- R6: A stopped source still produces done, with a count of zero.
- R7: Pass is set with done only when low ≤ count ≤ high, with both ends inclusive. Otherwise pass is low.
- R8: When enable and start are both low, the count reads zero from the second bus cycle after the write. With enable still high and start low, the count is kept.
- R9: Done, pass and the count stay fixed while start remains high. Done and pass clear once start is written low.
- R10: A change of the source select while start is high does not alter the clock being measured.
- R11: Lowering start before the gate has finished abandons the measurement. Done does not rise.
- R12: Start without enable runs no measurement. Done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain (also seeds the measured-domain reset) |
| ref_clk | input | 1 | Reference clock that times the gate |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| src_clk | input | NSRC | Candidate clocks, one bit per source |
| wr_en | input | 1 | Write strobe, bus domain |
| wr_addr | input | 1 | 0 selects the status word, 1 the limit word |
| wr_data | input | 32 | Write data |
| stat_word | output | 32 | Control/status word readback |
| limit_word | output | 32 | Limit word readback |

## Verification
The hardest situations to reach from the ports depend on the relative timing of three clock domains. One is an abort that lands mid-gate while the reference side is still counting. Another is a select change issued during a live measurement. A third is a source that never toggles, so the measured-domain counter is never clocked at all. The stimulus reaches these by running real measurements on clocks with known, deliberately unrelated periods (10, 20, 30, 1 ns, and a constant). It times writes by counted bus cycles into the roughly 4,200-cycle gate, and waits well past a full gate before judging that done must stay low. A bench-side model of the writable fields and flag-clearing rules is compared on every bus clock.

// File: rtl/freqwin_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clock frequency window checker.
// Field positions are fixed because software decodes them.
package freqwin_pkg;
    localparam int WORD_W     = 32;
    localparam int EN_BIT     = 0;
    localparam int START_BIT  = 1;
    localparam int SEL_LSB    = 2;
    localparam int DONE_BIT   = 6;
    localparam int PASS_BIT   = 7;
    localparam int CNT_LSB    = 16;
    localparam int LO_LSB     = 16;
    localparam int HI_LSB     = 0;
    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_LIMIT = 1'b1;

    // Reference-domain sequencer states
    typedef enum logic [2:0] {
        RS_IDLE   = 3'd0,
        RS_SETTLE = 3'd1,
        RS_GATE   = 3'd2,
        RS_DRAIN  = 3'd3,
        RS_HOLD   = 3'd4
    } ref_state_e;
endpackage

// File: rtl/freqwin_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser, one chain per bit.
// Assumes multi-bit inputs are quasi-static (change well before use),
// so per-bit skew does not matter to the consumer.
module freqwin_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages to settle metastability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/freqwin_src_mux.sv
`timescale 1ns/1ps
// Clock source selector with an enable gate.
// Assumes sel is held steady by the caller during a measurement;
// glitches at switch time fall outside the gate window.
module freqwin_src_mux #(
    parameter int NSRC  = 16,
    parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  src_clk,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic             clk_out
);
    logic picked;

    // Choose the requested source; out-of-range selects give a quiet clock
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) picked = src_clk[i];
        end
    end

    // Stop the clock entirely while disabled
    assign clk_out = en & picked;
endmodule

// File: rtl/freqwin_meas_cnt.sv
`timescale 1ns/1ps
// Edge counter in the measured-clock domain.
// Counts rising edges while the synchronised gate is high. The first
// edge of a gate restarts the count at zero, so the result is edges-1.
// The count saturates at all-ones. The epoch tag of the reference run
// is recorded on that first edge, which lets the reference side tell
// a fresh count from a stale one left by a clock that has since stopped.
// Assumes the reference side reads cnt/tag only after the gate has
// closed and drained, when both are static.
module freqwin_meas_cnt #(
    parameter int CNT_W = 14,
    parameter int TAG_W = 4
) (
    input  logic             meas_clk,
    input  logic             rst_src_n,
    input  logic             gate,
    input  logic [TAG_W-1:0] tag,
    output logic [CNT_W-1:0] cnt,
    output logic [TAG_W-1:0] cnt_tag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0]       rst_pipe;
    logic             meas_rst_n;
    logic             gate_s;
    logic             gate_q;
    logic [TAG_W-1:0] tag_s;

    // Local reset release aligned to the measured clock
    always_ff @(posedge meas_clk) begin
        if (!rst_src_n) rst_pipe <= 2'b00;
        else            rst_pipe <= {rst_pipe[0], 1'b1};
    end
    assign meas_rst_n = rst_pipe[1];

    freqwin_sync #(.W(1)) u_gate_sync (
        .clk(meas_clk), .rst_n(meas_rst_n), .d(gate), .q(gate_s)
    );

    freqwin_sync #(.W(TAG_W)) u_tag_sync (
        .clk(meas_clk), .rst_n(meas_rst_n), .d(tag), .q(tag_s)
    );

    // Gate edge history for start-of-window detection
    always_ff @(posedge meas_clk) begin
        if (!meas_rst_n) gate_q <= 1'b0;
        else             gate_q <= gate_s;
    end

    // Saturating edge count with epoch capture on the opening edge
    always_ff @(posedge meas_clk) begin
        if (!meas_rst_n) begin
            cnt     <= '0;
            cnt_tag <= '0;
        end else if (gate_s && !gate_q) begin
            cnt     <= '0;
            cnt_tag <= tag_s;
        end else if (gate_s && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: once full scale inside a gate, the count never wraps
    assert_cnt_saturates_R5: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
        (gate_s && gate_q && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/freqwin_ref_ctl.sv
`timescale 1ns/1ps
// Reference-domain sequencer.
// On a synchronised run request it bumps the epoch tag and waits
// SETTLE_CYC cycles so the tag reaches the measured domain. It then
// opens the gate for exactly GATE_CYC cycles and waits DRAIN_CYC more
// for the measured side to stop counting. Finally it samples the static
// count and publishes it with a toggle. Assumes a measured clock period
// of at most DRAIN_CYC/4 reference periods.
module freqwin_ref_ctl
    import freqwin_pkg::*;
#(
    parameter int GATE_CYC   = 512,
    parameter int SETTLE_CYC = 4,
    parameter int DRAIN_CYC  = 16,
    parameter int CNT_W      = 14,
    parameter int TAG_W      = 4
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             en_bus,
    input  logic             start_bus,
    input  logic [CNT_W-1:0] meas_cnt,
    input  logic [TAG_W-1:0] meas_tag,
    output logic             gate,
    output logic [TAG_W-1:0] tag,
    output logic [CNT_W-1:0] result,
    output logic             res_tog
);
    localparam int SPAN  = (GATE_CYC > DRAIN_CYC) ? GATE_CYC : DRAIN_CYC;
    localparam int TMR_W = $clog2(SPAN + SETTLE_CYC) + 1;
    localparam logic [TAG_W-1:0] TAG_MAX = '1;

    ref_state_e       st;
    logic [TMR_W-1:0] tmr;
    logic [1:0]       req_s;
    logic             run_s;
    logic [TAG_W-1:0] tag_next;

    freqwin_sync #(.W(2)) u_req_sync (
        .clk(ref_clk), .rst_n(ref_rst_n), .d({start_bus, en_bus}), .q(req_s)
    );
    assign run_s = req_s[0] & req_s[1];

    // Next epoch, skipping zero so a never-clocked counter cannot match
    assign tag_next = (tag == TAG_MAX) ? TAG_W'(1) : tag + 1'b1;

    // Sequencer: settle, gate, drain, capture, hold until released
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            st      <= RS_IDLE;
            tmr     <= '0;
            gate    <= 1'b0;
            tag     <= '0;
            result  <= '0;
            res_tog <= 1'b0;
        end else begin
            case (st)
                RS_IDLE: begin
                    gate <= 1'b0;
                    if (run_s) begin
                        tag <= tag_next;
                        tmr <= '0;
                        st  <= RS_SETTLE;
                    end
                end
                RS_SETTLE: begin
                    if (!run_s) begin
                        st <= RS_IDLE;
                    end else if (tmr == TMR_W'(SETTLE_CYC - 1)) begin
                        tmr  <= '0;
                        gate <= 1'b1;
                        st   <= RS_GATE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                RS_GATE: begin
                    if (!run_s) begin
                        gate <= 1'b0;
                        st   <= RS_IDLE;
                    end else if (tmr == TMR_W'(GATE_CYC - 1)) begin
                        gate <= 1'b0;
                        tmr  <= '0;
                        st   <= RS_DRAIN;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                RS_DRAIN: begin
                    if (!run_s) begin
                        st <= RS_IDLE;
                    end else if (tmr == TMR_W'(DRAIN_CYC - 1)) begin
                        result  <= (meas_tag == tag) ? meas_cnt : '0;
                        res_tog <= ~res_tog;
                        st      <= RS_HOLD;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                RS_HOLD: begin
                    if (!run_s) st <= RS_IDLE;
                end
                default: st <= RS_IDLE;
            endcase
        end
    end

    // R4: the gate closes right after its last counted cycle
    assert_gate_closes_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (st == RS_GATE && tmr == TMR_W'(GATE_CYC - 1) && run_s) |=> (!gate && st == RS_DRAIN));

    // R4: a result is published only on leaving the drain phase
    assert_publish_after_drain_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !$stable(res_tog) |-> (st == RS_HOLD && $past(st) == RS_DRAIN));

    // R11: a withdrawn request shuts the gate
    assert_abort_closes_gate_R11: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !run_s |=> !gate);
endmodule

// File: rtl/freqwin_checker.sv
`timescale 1ns/1ps
// Clock frequency window checker, top level.
// Holds the bus-side control and limit registers, freezes the source
// select during a run, and drives the source mux. It instantiates the
// reference sequencer and measured-domain counter, receives the result
// through a toggle handshake, and raises done and pass.
// Assumes NSRC <= 16 and CNT_W <= 14 so the fields fit the word layout.
module freqwin_checker
    import freqwin_pkg::*;
#(
    parameter int NSRC       = 16,
    parameter int CNT_W      = 14,
    parameter int GATE_CYC   = 512,
    parameter int SETTLE_CYC = 4,
    parameter int DRAIN_CYC  = 16,
    parameter int TAG_W      = 4
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic [NSRC-1:0]   src_clk,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       stat_word,
    output logic [31:0]       limit_word
);
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic             en_q, start_q;
    logic [SEL_W-1:0] sel_reg, sel_eff;
    logic [CNT_W-1:0] lim_lo, lim_hi;
    logic             done_q, pass_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tog_s, tog_q, arrive;
    logic             meas_clk;
    logic             gate;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] meas_cnt, result;
    logic [TAG_W-1:0] meas_tag;
    logic             res_tog;
    logic             ctrl_wr, lim_wr;
    logic             in_window;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign lim_wr  = wr_en && (wr_addr == ADDR_LIMIT);

    // Software-written control fields
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
            sel_reg <= '0;
        end else if (ctrl_wr) begin
            en_q    <= wr_data[EN_BIT];
            start_q <= wr_data[START_BIT];
            sel_reg <= wr_data[SEL_LSB +: SEL_W];
        end
    end

    // Software-written window bounds
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            lim_lo <= '0;
            lim_hi <= '0;
        end else if (lim_wr) begin
            lim_lo <= wr_data[LO_LSB +: CNT_W];
            lim_hi <= wr_data[HI_LSB +: CNT_W];
        end
    end

    // Select seen by the mux: follows the register only while start is low
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)    sel_eff <= '0;
        else if (!start_q) sel_eff <= sel_reg;
    end

    freqwin_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
        .src_clk(src_clk), .sel(sel_eff), .en(en_q), .clk_out(meas_clk)
    );

    freqwin_meas_cnt #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_meas (
        .meas_clk(meas_clk), .rst_src_n(bus_rst_n), .gate(gate), .tag(tag),
        .cnt(meas_cnt), .cnt_tag(meas_tag)
    );

    freqwin_ref_ctl #(
        .GATE_CYC(GATE_CYC), .SETTLE_CYC(SETTLE_CYC), .DRAIN_CYC(DRAIN_CYC),
        .CNT_W(CNT_W), .TAG_W(TAG_W)
    ) u_ref (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .en_bus(en_q), .start_bus(start_q),
        .meas_cnt(meas_cnt), .meas_tag(meas_tag), .gate(gate), .tag(tag),
        .result(result), .res_tog(res_tog)
    );

    freqwin_sync #(.W(1)) u_tog_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(res_tog), .q(tog_s)
    );

    // Toggle history for arrival detection
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) tog_q <= 1'b0;
        else            tog_q <= tog_s;
    end
    assign arrive = tog_s ^ tog_q;

    assign in_window = (result >= lim_lo) && (result <= lim_hi);

    // Done and pass: set on arrival during a run, dropped when start falls
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n || !start_q) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else if (arrive && en_q && !done_q) begin
            done_q <= 1'b1;
            pass_q <= in_window;
        end
    end

    // Returned count: loaded on arrival, zeroed on the clear step
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n || (!en_q && !start_q)) cnt_q <= '0;
        else if (arrive && start_q && en_q && !done_q) cnt_q <= result;
    end

    // Readback assembly
    always_comb begin
        stat_word = '0;
        stat_word[EN_BIT]               = en_q;
        stat_word[START_BIT]            = start_q;
        stat_word[SEL_LSB +: SEL_W]     = sel_reg;
        stat_word[DONE_BIT]             = done_q;
        stat_word[PASS_BIT]             = pass_q;
        stat_word[CNT_LSB +: CNT_W]     = cnt_q;
        limit_word = '0;
        limit_word[LO_LSB +: CNT_W]     = lim_lo;
        limit_word[HI_LSB +: CNT_W]     = lim_hi;
    end

    // R7: pass never stands without done
    assert_pass_implies_done_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        pass_q |-> done_q);

    // R8: the clear step zeroes the count on the next edge
    assert_clear_zeroes_count_R8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!en_q && !start_q) |=> (cnt_q == '0));

    // R9: releasing start drops both flags
    assert_flags_drop_R9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !start_q |=> (!done_q && !pass_q));

    // R10: the mux select is frozen for the duration of a run
    assert_sel_frozen_R10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (start_q && $past(start_q)) |-> $stable(sel_eff));
endmodule

// File: tb/freqwin_checker_test.sv
`timescale 1ns/1ps
// Bench for freqwin_checker: bus clock 200 MHz, reference 25 MHz.
module freqwin_checker_test;
    logic bus_clk = 1'b0, ref_clk = 1'b0;
    logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0, cx = 1'b0;
    logic bus_rst_n = 1'b0, ref_rst_n = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] stat_word, limit_word;
    logic [15:0] src_clk;

    always #2.5  bus_clk = ~bus_clk;
    always #20   ref_clk = ~ref_clk;
    always #5    c0 = ~c0;   // 10 ns
    always #10   c1 = ~c1;   // 20 ns
    always #15   c2 = ~c2;   // 30 ns
    always #0.5  c3 = ~c3;   // 1 ns, overflows the count
    always #4    cx = ~cx;   // 8 ns filler
    assign src_clk = {1'b0, {11{cx}}, c3, c2, c1, c0};  // source 15 stopped

    freqwin_checker uut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .src_clk(src_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stat_word(stat_word), .limit_word(limit_word)
    );

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    // Behavioural model of the writable state
    logic [5:0]  m_ctrl = '0;
    logic [31:0] m_lim  = '0;
    bit          mon_on = 1'b0;
    bit          p_start = 1'b0, p_clr = 1'b1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge bus_clk) begin
        if (mon_on) begin
            chk(stat_word[5:0] == m_ctrl, "R2", stat_word[5:0], m_ctrl);
            chk(stat_word[31:30] == 0 && stat_word[15:8] == 0, "R2", stat_word, 0);
            chk(limit_word == m_lim, "R3", limit_word, m_lim);
            if (!m_ctrl[1] && !p_start)
                chk(stat_word[7:6] == 0, "R9", stat_word[7:6], 0);
            if (m_ctrl[1:0] == 0 && p_clr)
                chk(stat_word[29:16] == 0, "R8", stat_word[29:16], 0);
            p_start = m_ctrl[1];
            p_clr   = (m_ctrl[1:0] == 0);
        end
    end

    task automatic bus_write(input logic addr, input logic [31:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = d;
        @(posedge bus_clk);
        #0.5;
        if (addr) m_lim = d & 32'h3FFF_3FFF;
        else      m_ctrl = d[5:0];
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 8000; i++) begin
            @(negedge bus_clk);
            if (stat_word[6]) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_meas(input int sel, input int lo, input int hi,
                            output int cnt, output bit dn, output bit ps);
        bus_write(1'b1, (32'(lo) << 16) | 32'(hi));
        bus_write(1'b0, 32'h0);
        repeat (4) @(negedge bus_clk);
        bus_write(1'b0, 32'h1 | (32'(sel) << 2));
        repeat (20) @(negedge bus_clk);
        bus_write(1'b0, 32'h3 | (32'(sel) << 2));
        wait_done(dn);
        cnt = int'(stat_word[29:16]);
        ps  = stat_word[7];
    endtask

    function automatic bit near(input int act, input real period);
        real e;
        e = 512.0 * 40.0 / period - 1.0;
        return (real'(act) >= e - 1.5) && (real'(act) <= e + 1.5);
    endfunction

    initial begin
        repeat (190000) @(posedge bus_clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int  cnt, keep;
        bit  dn, ps;
        repeat (10) @(negedge bus_clk);
        bus_rst_n = 1'b1; ref_rst_n = 1'b1;
        @(negedge bus_clk);
        // R1 reset state
        chk(stat_word == 0, "R1", stat_word, 0);
        chk(limit_word == 0, "R1", limit_word, 0);
        mon_on = 1'b1;

        // R3 limit fields, spare bits dropped
        bus_write(1'b1, 32'h0123_0456);
        bus_write(1'b1, 32'hFFFF_FFFF);
        @(negedge bus_clk);
        chk(limit_word == 32'h3FFF_3FFF, "R3", limit_word, 32'h3FFF_3FFF);
        // R2 control fields
        bus_write(1'b0, 32'hFFFF_FF15);
        @(negedge bus_clk);
        chk(stat_word[5:0] == 6'h15, "R2", stat_word[5:0], 6'h15);
        bus_write(1'b0, 32'h0);

        // R4/R7: 20 ns source inside its window
        run_meas(1, 1002, 1043, cnt, dn, ps);
        chk(dn, "R4", dn, 1);
        chk(near(cnt, 20.0), "R4", cnt, 1023);
        chk(ps, "R7", ps, 1);
        // R9: flags and count held while start stays high
        keep = cnt;
        repeat (300) @(negedge bus_clk);
        chk(stat_word[6] && stat_word[29:16] == keep, "R9", stat_word[29:16], keep);
        bus_write(1'b0, 32'h1 | (32'd1 << 2));
        @(negedge bus_clk);
        chk(stat_word[7:6] == 0, "R9", stat_word[7:6], 0);
        chk(stat_word[29:16] == keep, "R8", stat_word[29:16], keep);
        bus_write(1'b0, 32'h0);
        @(negedge bus_clk);
        chk(stat_word[29:16] == 0, "R8", stat_word[29:16], 0);

        // R4/R7: 10 ns source, window excludes it
        run_meas(0, 0, 1000, cnt, dn, ps);
        chk(dn && near(cnt, 10.0), "R4", cnt, 2047);
        chk(!ps, "R7", ps, 0);
        // R4: 30 ns source, non-integer ratio
        run_meas(2, 668, 695, cnt, dn, ps);
        chk(dn && near(cnt, 30.0), "R4", cnt, 682);
        chk(ps, "R7", ps, 1);
        // R5: overflowing source, upper bound inclusive
        run_meas(3, 16383, 16383, cnt, dn, ps);
        chk(dn && cnt == 16383, "R5", cnt, 16383);
        chk(ps, "R7", ps, 1);
        run_meas(3, 0, 16382, cnt, dn, ps);
        chk(cnt == 16383 && !ps, "R5", {cnt, ps}, {16383, 1'b0});
        // R6: stopped source
        run_meas(15, 1, 100, cnt, dn, ps);
        chk(dn, "R6", dn, 1);
        chk(cnt == 0, "R6", cnt, 0);
        chk(!ps, "R6", ps, 0);
        // R7: lower bound inclusive
        run_meas(15, 0, 0, cnt, dn, ps);
        chk(dn && ps, "R7", ps, 1);

        // R10: select change mid-run is ignored
        bus_write(1'b1, (32'd1002 << 16) | 32'd1043);
        bus_write(1'b0, 32'h0);
        bus_write(1'b0, 32'h1 | (32'd1 << 2));
        repeat (20) @(negedge bus_clk);
        bus_write(1'b0, 32'h3 | (32'd1 << 2));
        repeat (1000) @(negedge bus_clk);
        bus_write(1'b0, 32'h3 | (32'd0 << 2));
        wait_done(dn);
        cnt = int'(stat_word[29:16]);
        chk(dn && near(cnt, 20.0), "R10", cnt, 1023);

        // R11: abort mid-gate
        bus_write(1'b0, 32'h0);
        bus_write(1'b0, 32'h1 | (32'd1 << 2));
        repeat (20) @(negedge bus_clk);
        bus_write(1'b0, 32'h3 | (32'd1 << 2));
        repeat (1500) @(negedge bus_clk);
        bus_write(1'b0, 32'h1 | (32'd1 << 2));
        repeat (6000) @(negedge bus_clk);
        chk(!stat_word[6], "R11", stat_word[6], 0);
        run_meas(1, 1002, 1043, cnt, dn, ps);
        chk(dn && near(cnt, 20.0) && ps, "R11", cnt, 1023);

        // R12: start without enable
        bus_write(1'b0, 32'h0);
        bus_write(1'b0, 32'h2 | (32'd1 << 2));
        repeat (6000) @(negedge bus_clk);
        chk(!stat_word[6], "R12", stat_word[6], 0);
        chk(stat_word[29:16] == 0, "R12", stat_word[29:16], 0);
        bus_write(1'b0, 32'h0);

        finished = 1'b1;
        mon_on = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule